// File: doc/BRIEF.md
# Token-Passing Two-Input State Controller

This block is a four-state controller driven by two single-bit condition inputs and producing two single-bit outputs. A parameter fixes it at build time to one of two behaviours, each with its own hard-wired transition table. In the transition-output (Mealy) variant the outputs belong to the transition taken in the current cycle. In the state-output (Moore) variant the outputs belong to the current state alone. The states are named A, B, C and D, and A is both the idle state and the home state.

The controller sleeps in state A until it receives a one-cycle start pulse. It then walks its table, one step per enabled cycle. When a step brings it back into A, it emits a one-cycle finish pulse and goes back to sleep. If the finish output of one controller is wired to the start input of the next, a token passes along a chain of controllers, and only one of them is active at a time. The enable input qualifies every state update. Tie it high when it is not needed.

The conditions of a state are tried in table order and the first match wins. A cycle in which no condition matches keeps the state and drives both outputs to 0. The conditions of every state in both tables cover all input combinations, so this fallback is a safety net and never changes the visible behaviour.

Top module: `token_fsm_ctrl`

## Requirements
- R1: While reset is asserted and after reset is released, the controller is idle in state A with q1=0, q0=0 and finish=0.
- R2: While idle, both outputs are 0. A start pulse sampled at a clock edge with en=1 makes the controller active from the next cycle, still in state A. A start pulse with en=0, or a start pulse while the controller is active, is ignored.
- R3: Mealy variant, state A: if (a|b) the next state is B and the outputs are q1q0=11; otherwise the next state is C and the outputs are 10. Outputs follow the inputs in the same cycle.
- R4: Mealy variant, other states. From B: ~a&b gives A/00, ~a&~b gives B/01, a&~b gives C/11, a&b gives D/10. From C: ~a&b gives A/00, ~b gives B/01, a&b gives D/11. From D: a&b gives A/10, and ~a|~b gives C/00. Conditions are tried in this order.
- R5: Moore variant: while active, q1q0 is 11 in A, 01 in B, 00 in C and 10 in D, whatever the inputs.
- R6: Moore variant transitions. From A: ~b gives C and b gives D. From B: ~a gives C and a gives D. From C: a&~b gives A, ~a&~b gives B, and b stays in C. From D: ~a&~b gives A, a&b gives C, and a^b stays in D.
- R7: In a cycle with en=0 the state and the active flag hold. In the Mealy variant both outputs are 0 in that cycle.
- R8: When an enabled step moves an active controller from another state into A, finish is 1 for exactly the next cycle, and the controller is idle in A during that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Qualifies every state update (tie high if unused) |
| start | input | 1 | One-cycle activation pulse (token in) |
| in_a | input | 1 | Condition input a |
| in_b | input | 1 | Condition input b |
| q1 | output | 1 | Output bit 1 |
| q0 | output | 1 | Output bit 0 |
| finish | output | 1 | One-cycle completion pulse (token out) |

## Verification
In the Mealy variant, a wrong next state shows up on q1/q0 in the very next enabled cycle, because each state drives a different output pattern for some input combination. In the Moore variant the output code is unique per state, so a wrong state shows at the ports one cycle after the faulty step. A wrong active flag shows either as non-zero outputs while the controller should be idle or as a missing or extra finish pulse. The bench drives a Mealy and a Moore instance in parallel with the same random and directed stimulus, and compares both against a bench-side model on every cycle.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_A = 2'd0,
        ST_B = 2'd1,
        ST_C = 2'd2,
        ST_D = 2'd3
    } tfc_state_e;

    typedef struct packed {
        logic q1;
        logic q0;
    } tfc_out_t;

    localparam tfc_out_t OUT_ZERO = '{q1: 1'b0, q0: 1'b0};

endpackage

// File: rtl/tfc_mealy_logic.sv
module tfc_mealy_logic
    import tfc_pkg::*;
(
    input  tfc_state_e cur,
    input  logic       a,
    input  logic       b,
    output tfc_state_e nxt,
    output tfc_out_t   outv,
    output logic       hit
);

    // Transition-output table; first matching condition wins.
    always_comb begin
        nxt  = cur;
        outv = OUT_ZERO;
        hit  = 1'b0;
        unique case (cur)
            ST_A: begin
                if (a | b) begin
                    nxt = ST_B; outv = '{1'b1, 1'b1}; hit = 1'b1;
                end else if (~a & ~b) begin
                    nxt = ST_C; outv = '{1'b1, 1'b0}; hit = 1'b1;
                end
            end
            ST_B: begin
                if (~a & b) begin
                    nxt = ST_A; outv = '{1'b0, 1'b0}; hit = 1'b1;
                end else if (~a & ~b) begin
                    nxt = ST_B; outv = '{1'b0, 1'b1}; hit = 1'b1;
                end else if (a & ~b) begin
                    nxt = ST_C; outv = '{1'b1, 1'b1}; hit = 1'b1;
                end else if (a & b) begin
                    nxt = ST_D; outv = '{1'b1, 1'b0}; hit = 1'b1;
                end
            end
            ST_C: begin
                if (~a & b) begin
                    nxt = ST_A; outv = '{1'b0, 1'b0}; hit = 1'b1;
                end else if (~b) begin
                    nxt = ST_B; outv = '{1'b0, 1'b1}; hit = 1'b1;
                end else if (a & b) begin
                    nxt = ST_D; outv = '{1'b1, 1'b1}; hit = 1'b1;
                end
            end
            ST_D: begin
                if (a & b) begin
                    nxt = ST_A; outv = '{1'b1, 1'b0}; hit = 1'b1;
                end else if (~b | ~a) begin
                    nxt = ST_C; outv = '{1'b0, 1'b0}; hit = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/tfc_moore_logic.sv
module tfc_moore_logic
    import tfc_pkg::*;
(
    input  tfc_state_e cur,
    input  logic       a,
    input  logic       b,
    output tfc_state_e nxt,
    output tfc_out_t   outv,
    output logic       hit
);

    // State-output table.
    always_comb begin
        unique case (cur)
            ST_A: outv = '{1'b1, 1'b1};
            ST_B: outv = '{1'b0, 1'b1};
            ST_C: outv = '{1'b0, 1'b0};
            ST_D: outv = '{1'b1, 1'b0};
        endcase
    end

    // Transition table; first matching condition wins.
    always_comb begin
        nxt = cur;
        hit = 1'b0;
        unique case (cur)
            ST_A: begin
                if (~b)     begin nxt = ST_C; hit = 1'b1; end
                else if (b) begin nxt = ST_D; hit = 1'b1; end
            end
            ST_B: begin
                if (~a)     begin nxt = ST_C; hit = 1'b1; end
                else if (a) begin nxt = ST_D; hit = 1'b1; end
            end
            ST_C: begin
                if (a & ~b)       begin nxt = ST_A; hit = 1'b1; end
                else if (~a & ~b) begin nxt = ST_B; hit = 1'b1; end
                else if (b)       begin nxt = ST_C; hit = 1'b1; end
            end
            ST_D: begin
                if (~a & ~b)     begin nxt = ST_A; hit = 1'b1; end
                else if (a & b)  begin nxt = ST_C; hit = 1'b1; end
                else if (a ^ b)  begin nxt = ST_D; hit = 1'b1; end
            end
        endcase
    end

endmodule

// File: rtl/token_fsm_ctrl.sv
module token_fsm_ctrl
    import tfc_pkg::*;
#(
    parameter bit IS_MOORE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic in_a,
    input  logic in_b,
    output logic q1,
    output logic q0,
    output logic finish
);

    tfc_state_e state_q;
    logic       active_q;
    logic       finish_q;
    tfc_state_e tbl_nxt;
    tfc_out_t   tbl_out;
    logic       tbl_hit;
    tfc_out_t   out_c;

    generate
        if (IS_MOORE) begin : g_moore
            tfc_moore_logic u_tbl (
                .cur (state_q),
                .a   (in_a),
                .b   (in_b),
                .nxt (tbl_nxt),
                .outv(tbl_out),
                .hit (tbl_hit)
            );
        end else begin : g_mealy
            tfc_mealy_logic u_tbl (
                .cur (state_q),
                .a   (in_a),
                .b   (in_b),
                .nxt (tbl_nxt),
                .outv(tbl_out),
                .hit (tbl_hit)
            );
        end
    endgenerate

    // State register, activity flag and token-out pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_A;
            active_q <= 1'b0;
            finish_q <= 1'b0;
        end else begin
            finish_q <= 1'b0;
            if (en) begin
                if (active_q) begin
                    state_q <= tbl_nxt;
                    if (tbl_nxt == ST_A && state_q != ST_A) begin
                        active_q <= 1'b0;
                        finish_q <= 1'b1;
                    end
                end else if (start) begin
                    active_q <= 1'b1;
                end
            end
        end
    end

    // Output process.
    always_comb begin
        out_c = OUT_ZERO;
        if (active_q) begin
            if (IS_MOORE) begin
                out_c = tbl_out;
            end else if (en && tbl_hit) begin
                out_c = tbl_out;
            end
        end
    end

    assign q1     = out_c.q1;
    assign q0     = out_c.q0;
    assign finish = finish_q;

    // R8
    finish_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);

    // R8
    finish_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> (state_q == ST_A && !active_q));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (!q1 && !q0));

    // R7
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(state_q) && $stable(active_q)));

    // R7
    mealy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_MOORE && !en) |-> (!q1 && !q0));

    // R2
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_q && en && start) |=> (active_q && state_q == ST_A));

endmodule

// File: tb/token_fsm_ctrl_bench.sv
`timescale 1ns/1ps
module token_fsm_ctrl_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, start = 1'b0, a = 1'b0, b = 1'b0;
    logic ml_q1, ml_q0, ml_fin, mo_q1, mo_q0, mo_fin;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    int   m_st  [2];
    bit   m_act [2];
    bit   m_fin [2];

    always #2 clk = ~clk;

    token_fsm_ctrl #(.IS_MOORE(1'b0)) u_token_fsm_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start),
        .in_a(a), .in_b(b), .q1(ml_q1), .q0(ml_q0), .finish(ml_fin));

    token_fsm_ctrl #(.IS_MOORE(1'b1)) u_moore (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start),
        .in_a(a), .in_b(b), .q1(mo_q1), .q0(mo_q0), .finish(mo_fin));

    // State numbering in the model: A=0, B=1, C=2, D=3.
    function automatic int ref_next(bit moore, int s, bit x, bit y);
        int r;
        r = s;
        if (!moore) begin
            case (s)
                0: r = (x | y) ? 1 : 2;
                1: if (!x && y) r = 0; else if (!x && !y) r = 1;
                   else if (x && !y) r = 2; else r = 3;
                2: if (!x && y) r = 0; else if (!y) r = 1; else r = 3;
                default: r = (x && y) ? 0 : 2;
            endcase
        end else begin
            case (s)
                0: r = y ? 3 : 2;
                1: r = x ? 3 : 2;
                2: if (x && !y) r = 0; else if (!x && !y) r = 1; else r = 2;
                default: if (!x && !y) r = 0; else if (x && y) r = 2; else r = 3;
            endcase
        end
        return r;
    endfunction

    function automatic logic [1:0] ref_out(bit moore, int s, bit x, bit y);
        logic [1:0] r;
        if (moore) begin
            case (s)
                0: r = 2'b11;
                1: r = 2'b01;
                2: r = 2'b00;
                default: r = 2'b10;
            endcase
        end else begin
            case (s)
                0: r = (x | y) ? 2'b11 : 2'b10;
                1: if (!x && y) r = 2'b00; else if (!x && !y) r = 2'b01;
                   else if (x && !y) r = 2'b11; else r = 2'b10;
                2: if (!x && y) r = 2'b00; else if (!y) r = 2'b01; else r = 2'b11;
                default: r = (x && y) ? 2'b10 : 2'b00;
            endcase
        end
        return r;
    endfunction

    task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] dut_q(int m);
        return (m == 0) ? {ml_q1, ml_q0} : {mo_q1, mo_q0};
    endfunction

    function automatic logic dut_f(int m);
        return (m == 0) ? ml_fin : mo_fin;
    endfunction

    // Drive one cycle, check both instances, advance the model.
    task automatic step(bit e, bit s, bit x, bit y);
        @(negedge clk);
        en = e; start = s; a = x; b = y;
        #1;
        for (int m = 0; m < 2; m++) begin
            logic [1:0] exp_q;
            string tag;
            if (!m_act[m]) begin
                exp_q = 2'b00; tag = "R2 idle outputs";
            end else if (m == 1) begin
                exp_q = ref_out(1'b1, m_st[m], x, y); tag = "R5 R6 moore outputs";
            end else if (!e) begin
                exp_q = 2'b00; tag = "R7 mealy disabled";
            end else begin
                exp_q = ref_out(1'b0, m_st[m], x, y);
                tag = (m_st[m] == 0) ? "R3 mealy from A" : "R4 mealy transition";
            end
            check(tag, dut_q(m), exp_q);
            check("R8 finish", {1'b0, dut_f(m)}, {1'b0, m_fin[m]});
        end
        for (int m = 0; m < 2; m++) begin
            m_fin[m] = 1'b0;
            if (e) begin
                if (m_act[m]) begin
                    int n;
                    n = ref_next(m == 1, m_st[m], x, y);
                    if (n == 0 && m_st[m] != 0) begin
                        m_act[m] = 1'b0;
                        m_fin[m] = 1'b1;
                    end
                    m_st[m] = n;
                end else if (s) begin
                    m_act[m] = 1'b1;
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++) begin
            m_st[m] = 0; m_act[m] = 1'b0; m_fin[m] = 1'b0;
        end
        en = 1'b1; start = 1'b1; a = 1'b1; b = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 reset mealy q", {ml_q1, ml_q0}, 2'b00);
        check("R1 reset moore q", {mo_q1, mo_q0}, 2'b00);
        check("R1 reset finish", {ml_fin, mo_fin}, 2'b00);
        start = 1'b0;
        rst_n = 1'b1;

        step(1, 0, 1, 1);
        // R2: start with en low is ignored
        step(0, 1, 1, 0);
        step(1, 0, 1, 0);
        check("R2 start with en low ignored", {ml_q1, ml_q0}, 2'b00);
        // Activate, then Mealy A with a=1 gives 11 (R3)
        step(1, 1, 0, 0);
        step(1, 0, 1, 0);
        check("R3 mealy A a=1", {ml_q1, ml_q0}, 2'b11);
        check("R5 moore A", {mo_q1, mo_q0}, 2'b11);
        // Mealy now in B: ~a&b returns to A with 00 (R4); start while active ignored (R2)
        step(1, 1, 0, 1);
        check("R4 mealy B to A", {ml_q1, ml_q0}, 2'b00);
        step(1, 0, 0, 0);
        check("R8 mealy finish pulse", {1'b0, ml_fin}, 2'b01);
        step(1, 0, 0, 0);
        check("R8 finish lasts one cycle", {1'b0, ml_fin}, 2'b00);
        // Enable held low while active (R7)
        step(1, 1, 0, 0);
        for (int i = 0; i < 5; i++) begin
            step(0, 0, i[0], i[1]);
            check("R7 mealy silent when en low", {ml_q1, ml_q0}, 2'b00);
        end
        for (int i = 0; i < 40; i++) step(1, 0, i[0], i[2]);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            bit e, s, x, y;
            e = ($urandom % 8) != 0;
            s = ($urandom % 6) == 0;
            x = $urandom % 2;
            y = $urandom % 2;
            step(e, s, x, y);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule